// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the control unit of a microcoded processor. A microprogram counter selects one word of an on-chip control store. On every clock that word is captured in the microinstruction register, and the register's fields drive the datapath control lines. The address of the following microinstruction comes from the current microinstruction's next-address field. A three-bit jump field can modify that address in two ways: it can OR the registered negative and zero flags into the top address bit, giving a two-way conditional branch, or it can OR an 8-bit opcode byte into the low address bits, giving a multiway dispatch. No adder and no branch table are involved.

The control store is written through a simple load port. The port accepts writes only while the sequencer is held in reset, so a test environment or boot loader can place a microprogram before execution starts. The datapath that consumes the control fields is outside this block.

Top module: `useq_top`

## Requirements
- R1: When all three jump bits of the current microinstruction are zero, the next microprogram counter value equals its 9-bit next-address field exactly, whatever the flag and opcode inputs are.
- R2: After each clock out of reset, the microinstruction outputs equal the control store word at the new counter value. The word layout is: next address at bits [35:27], jump field at [26:24], ALU control at [23:16], C-select at [15:7], memory control at [6:4], B-select at [3:0].
- R3: Jump bit 0 (negative-branch) ORs the `nFlag` input into address bit 8. Jump bit 1 (zero-branch) ORs the `zFlag` input into address bit 8. With both bits set, both flags are ORed in. A bit 8 already set in the next-address field stays set.
- R4: Jump bit 2 (dispatch) ORs the 8-bit `opcode` input bitwise into address bits [7:0] of the next address. With that jump bit clear, bits [7:0] equal the next-address field.
- R5: While `rstN` is low at a clock edge, the counter becomes 0 and every microinstruction output becomes 0. The first edge with `rstN` high loads address 0 and captures word 0.
- R6: A load-port write (`ldEn` high) at an edge with `rstN` low stores `ldData` at `ldAddr`. A write attempted while `rstN` is high leaves the control store unchanged.
- R7: Flags and opcode are taken as the values present at the clock edge that advances the counter. Values they hold between edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also enables store loading |
| nFlag | input | 1 | Registered negative flag from the datapath |
| zFlag | input | 1 | Registered zero flag from the datapath |
| opcode | input | 8 | Fetched instruction byte used for dispatch |
| ldEn | input | 1 | Control store write strobe |
| ldAddr | input | 9 | Control store write address |
| ldData | input | 36 | Control store write word |
| mpc | output | 9 | Current microprogram counter |
| mirNext | output | 9 | Next-address field of the current microinstruction |
| mirJam | output | 3 | Jump field (bit0 negative, bit1 zero, bit2 dispatch) |
| mirAlu | output | 8 | ALU control field |
| mirCSel | output | 9 | C-bus register select field |
| mirMem | output | 3 | Memory control field |
| mirBSel | output | 4 | B-bus source select field |

## Verification
The assertions check the address rules on every clock out of reset. The counter must match the next-address field when no jump bit is set, bit 8 must follow the flag OR, the low byte must follow the dispatch OR, the register must track the store word at the counter, and no store write may occur outside reset. Some behaviours only the bench's scenarios can show. One is that a write attempted during execution leaves a word unchanged, which becomes visible only when the program later reaches that word. Others are the exact reset contents and long randomized walks through a random microprogram driven by random flags and opcodes, all compared against an independent model of the store.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Jump field bit positions.
  localparam int JAM_W = 3;
  localparam int JAM_N = 0;
  localparam int JAM_Z = 1;
  localparam int JAM_C = 2;

  // Strobes from the control half to the storage half.
  typedef struct packed {
    logic wrEn;     // write the control store this edge
    logic advance;  // step the counter and capture a word
  } strobe_t;
endpackage

// File: rtl/useq_control.sv
module useq_control
  import useq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OPC_W  = 8
) (
  input  logic                 rstN,
  input  logic                 ldEn,
  input  logic                 nFlag,
  input  logic                 zFlag,
  input  logic [JAM_W-1:0]     jam,
  input  logic [ADDR_W-1:0]    nextField,
  input  logic [OPC_W-1:0]     opcode,
  output strobe_t              strobe,
  output logic [ADDR_W-1:0]    mpcNext
);
  localparam int TOP = ADDR_W - 1;
  localparam int PAD = ADDR_W - OPC_W;

  logic              highSet;
  logic [ADDR_W-1:0] dispMask;
  logic [ADDR_W-1:0] highMask;

  // Two-way branch: either enabled flag raises the top address bit.
  always_comb begin
    highSet  = (jam[JAM_N] & nFlag) | (jam[JAM_Z] & zFlag);
    highMask = '0;
    highMask[TOP] = highSet;
  end

  // Multiway dispatch: opcode lands in the low bits of the address.
  generate
    if (PAD > 0) begin : g_padOpc
      assign dispMask = jam[JAM_C] ? {{PAD{1'b0}}, opcode} : '0;
    end else begin : g_truncOpc
      assign dispMask = jam[JAM_C] ? opcode[ADDR_W-1:0] : '0;
    end
  endgenerate

  always_comb begin
    mpcNext        = nextField | dispMask | highMask;
    strobe.wrEn    = ldEn & ~rstN;
    strobe.advance = rstN;
  end
endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] mpcNext,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [WORD_W-1:0] ldData,
  output logic [ADDR_W-1:0] mpcQ,
  output logic [WORD_W-1:0] mirQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[ldAddr] <= ldData;
  end

  always_ff @(posedge clk) begin
    if (!strobe.advance) begin
      mpcQ <= '0;
      mirQ <= '0;
    end else begin
      mpcQ <= mpcNext;
      mirQ <= store[mpcNext];
    end
  end

  // R2: the register holds the store word the counter points at
  a_r2_mir_matches_store: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (mirQ == store[mpcQ]));

  // R6: the store is never written while running
  a_r6_no_run_write: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OPC_W  = 8,
  parameter int ALU_W  = 8,
  parameter int CSEL_W = 9,
  parameter int MEM_W  = 3,
  parameter int BSEL_W = 4,
  localparam int WORD_W = ADDR_W + JAM_W + ALU_W + CSEL_W + MEM_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nFlag,
  input  logic              zFlag,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [WORD_W-1:0] ldData,
  output logic [ADDR_W-1:0] mpc,
  output logic [ADDR_W-1:0] mirNext,
  output logic [JAM_W-1:0]  mirJam,
  output logic [ALU_W-1:0]  mirAlu,
  output logic [CSEL_W-1:0] mirCSel,
  output logic [MEM_W-1:0]  mirMem,
  output logic [BSEL_W-1:0] mirBSel
);
  localparam int BSEL_LO = 0;
  localparam int MEM_LO  = BSEL_LO + BSEL_W;
  localparam int CSEL_LO = MEM_LO + MEM_W;
  localparam int ALU_LO  = CSEL_LO + CSEL_W;
  localparam int JAM_LO  = ALU_LO + ALU_W;
  localparam int NEXT_LO = JAM_LO + JAM_W;
  localparam int TOP     = ADDR_W - 1;

  strobe_t           strobe;
  logic [ADDR_W-1:0] mpcNext;
  logic [WORD_W-1:0] mirQ;

  assign mirNext = mirQ[NEXT_LO +: ADDR_W];
  assign mirJam  = mirQ[JAM_LO  +: JAM_W];
  assign mirAlu  = mirQ[ALU_LO  +: ALU_W];
  assign mirCSel = mirQ[CSEL_LO +: CSEL_W];
  assign mirMem  = mirQ[MEM_LO  +: MEM_W];
  assign mirBSel = mirQ[BSEL_LO +: BSEL_W];

  useq_control #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_control (
    .rstN(rstN), .ldEn(ldEn), .nFlag(nFlag), .zFlag(zFlag),
    .jam(mirJam), .nextField(mirNext), .opcode(opcode),
    .strobe(strobe), .mpcNext(mpcNext)
  );

  useq_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mpcNext(mpcNext),
    .ldAddr(ldAddr), .ldData(ldData), .mpcQ(mpc), .mirQ(mirQ)
  );

  // R1: no jump bits means a plain copy of the next-address field
  a_r1_plain_copy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(mirJam) == '0)) |-> (mpc == $past(mirNext)));

  // R3: top bit is the field bit ORed with the enabled flags
  a_r3_flag_or: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (mpc[TOP] == ($past(mirNext[TOP])
      | ($past(mirJam[JAM_N]) & $past(nFlag))
      | ($past(mirJam[JAM_Z]) & $past(zFlag)))));

  // R4: dispatch ORs the opcode into the low bits
  a_r4_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mirJam[JAM_C])) |->
      (mpc[OPC_W-1:0] == ($past(mirNext[OPC_W-1:0]) | $past(opcode))));

  // R4: without dispatch the low bits pass unchanged
  a_r4_no_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(mirJam[JAM_C])) |->
      (mpc[OPC_W-1:0] == $past(mirNext[OPC_W-1:0])));
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nFlag = 1'b0, zFlag = 1'b0;
  logic [7:0]  opcode = '0;
  logic        ldEn = 1'b0;
  logic [8:0]  ldAddr = '0;
  logic [35:0] ldData = '0;
  logic [8:0]  mpc, mirNext, mirCSel;
  logic [2:0]  mirJam, mirMem;
  logic [7:0]  mirAlu;
  logic [3:0]  mirBSel;

  int checks = 0;
  int fails  = 0;
  logic [35:0] model [512];
  logic [35:0] modelMir;

  always #2.5 clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rstN(rstN), .nFlag(nFlag), .zFlag(zFlag), .opcode(opcode),
    .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData), .mpc(mpc),
    .mirNext(mirNext), .mirJam(mirJam), .mirAlu(mirAlu), .mirCSel(mirCSel),
    .mirMem(mirMem), .mirBSel(mirBSel)
  );

  function automatic logic [35:0] mkWord(logic [8:0] nxt, logic [2:0] j,
      logic [7:0] alu, logic [8:0] cs, logic [2:0] mem, logic [3:0] bs);
    return {nxt, j, alu, cs, mem, bs};
  endfunction

  // Expected next address from the requirement text (R1, R3, R4).
  function automatic logic [8:0] nextFn(logic [35:0] w, logic n, logic z, logic [7:0] o);
    logic [8:0] a;
    logic [2:0] j;
    a = w[35:27];
    j = w[26:24];
    if (j[0] && n) a[8] = 1'b1;
    if (j[1] && z) a[8] = 1'b1;
    if (j[2]) a[7:0] = a[7:0] | o;
    return a;
  endfunction

  function automatic logic [35:0] outWord();
    return {mirNext, mirJam, mirAlu, mirCSel, mirMem, mirBSel};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge with rstN low.
  task automatic loadWord(logic [8:0] a, logic [35:0] w);
    ldEn = 1'b1; ldAddr = a; ldData = w;
    model[a] = w;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // One running step; called at a negedge, returns at the next negedge.
  task automatic step(string req, logic n, logic z, logic [7:0] o);
    logic [8:0] expA;
    nFlag = n; zFlag = z; opcode = o;
    expA = nextFn(modelMir, n, z, o);
    @(posedge clk);
    #1;
    nFlag = ~n; zFlag = ~z; opcode = ~o;  // R7: between-edge values must not matter
    @(negedge clk);
    modelMir = model[expA];
    chk(req, 64'(mpc), 64'(expA));
    chk("R2", 64'(outWord()), 64'(modelMir));
  endtask

  task automatic enterReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic leaveReset();
    rstN = 1'b1;
    modelMir = '0;
  endtask

  task automatic dirCase(string req, logic [35:0] w0, logic n, logic z,
      logic [7:0] o, logic [8:0] expA);
    enterReset();
    loadWord(9'd0, w0);
    leaveReset();
    step("R5", 1'b1, 1'b1, 8'hFF);  // first edge after reset goes to word 0
    chk("R5", 64'(mpc), 64'd0);
    step(req, n, z, o);
    chk(req, 64'(mpc), 64'(expA));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    // R5: reset state
    chk("R5", 64'(mpc), 64'd0);
    chk("R5", 64'(outWord()), 64'd0);

    // R6: fill the store during reset with a pattern
    for (int a = 0; a < 512; a++) begin
      logic [8:0] av;
      av = 9'(a);
      loadWord(av, mkWord(av ^ 9'h0AA, 3'b000, av[7:0], ~av, av[2:0], av[3:0]));
    end
    leaveReset();
    step("R5", 1'b0, 1'b0, 8'h00);
    chk("R6", 64'(outWord()), 64'(model[0]));

    // R1: plain copy, flags and opcode all set
    dirCase("R1", mkWord(9'h0A5, 3'b000, 8'h11, 9'h1FF, 3'd5, 4'hC), 1'b1, 1'b1, 8'hFF, 9'h0A5);
    // R3: negative-branch
    dirCase("R3", mkWord(9'h033, 3'b001, 8'h22, 9'h001, 3'd1, 4'h1), 1'b1, 1'b0, 8'hFF, 9'h133);
    dirCase("R3", mkWord(9'h033, 3'b001, 8'h22, 9'h001, 3'd1, 4'h1), 1'b0, 1'b1, 8'hFF, 9'h033);
    // R3: zero-branch
    dirCase("R3", mkWord(9'h040, 3'b010, 8'h33, 9'h002, 3'd2, 4'h2), 1'b0, 1'b1, 8'h00, 9'h140);
    dirCase("R3", mkWord(9'h040, 3'b010, 8'h33, 9'h002, 3'd2, 4'h2), 1'b1, 1'b0, 8'h00, 9'h040);
    // R3: both enabled
    dirCase("R3", mkWord(9'h07E, 3'b011, 8'h44, 9'h004, 3'd3, 4'h3), 1'b0, 1'b1, 8'h00, 9'h17E);
    dirCase("R3", mkWord(9'h07E, 3'b011, 8'h44, 9'h004, 3'd3, 4'h3), 1'b0, 1'b0, 8'h00, 9'h07E);
    // R3: field bit 8 already set stays set
    dirCase("R3", mkWord(9'h1F0, 3'b001, 8'h55, 9'h008, 3'd4, 4'h4), 1'b0, 1'b0, 8'h00, 9'h1F0);
    // R4: dispatch
    dirCase("R4", mkWord(9'h100, 3'b100, 8'h66, 9'h010, 3'd6, 4'h5), 1'b1, 1'b1, 8'h5A, 9'h15A);
    dirCase("R4", mkWord(9'h0F0, 3'b100, 8'h77, 9'h020, 3'd7, 4'h6), 1'b0, 1'b0, 8'h0F, 9'h0FF);
    // R4: dispatch combined with a flag branch
    dirCase("R4", mkWord(9'h003, 3'b101, 8'h88, 9'h040, 3'd0, 4'h7), 1'b1, 1'b0, 8'h84, 9'h187);

    // R6: write attempt while running is ignored
    enterReset();
    loadWord(9'd0, mkWord(9'h1AB, 3'b000, 8'h99, 9'h080, 3'd1, 4'h8));
    leaveReset();
    ldEn = 1'b1; ldAddr = 9'h1AB; ldData = 36'hFACEC0DE5;
    step("R6", 1'b0, 1'b0, 8'h00);
    ldEn = 1'b0;
    step("R6", 1'b0, 1'b0, 8'h00);
    chk("R6", 64'(outWord()), 64'(model[9'h1AB]));

    // R5: reset mid-run clears the outputs
    rstN = 1'b0;
    @(negedge clk);
    chk("R5", 64'(mpc), 64'd0);
    chk("R5", 64'(outWord()), 64'd0);

    // Random microprogram walked with random flags and opcodes
    for (int a = 0; a < 512; a++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      loadWord(9'(a), r[35:0]);
    end
    leaveReset();
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r;
      r = $urandom();
      step("R1/R3/R4 random", r[0], r[1], r[15:8]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule